// File: doc/BRIEF.md
# Grouped Error Counter Snapshot Bank

This block keeps the line error counts of an eight-channel framed serial link and exposes them through a byte-wide register bus as stable holding buffers. Every error source has a live counter that increments once per clock cycle in which its event strobe is high. Software never reads the live counters directly. It reads holding buffers, and a snapshot loads those buffers.

A snapshot is taken in one of two ways. A write to the control register selects one of four counter groups with a 2-bit code. Every counter in that group is then copied into its buffer and cleared on the same clock edge, so the whole group covers exactly the same monitoring interval. A write to the upper byte address of one counter snapshots and clears that counter alone. The transmit retiming status fields share the snapshot mechanism. They are copied on a snapshot but never cleared, because they are levels and not counts.

Each source occupies one slot, and each slot occupies two byte addresses. The slots are ordered as follows: block CRC errors (rx channels 0..7, then tx channels 0..7), slip counts (positive 0..7, then negative 0..7), remote block errors (rx, then tx), retiming status (channels 0..7), frame alignment word errors (rx, then tx), and line code errors (rx 0..7). With eight channels this gives 80 slots.

Top module: `err_snap_bank`

## Requirements
- R1: After reset every live counter and every holding buffer is zero, and every bus address reads 0.
- R2: Slot s is read at byte address 2s for bits 7:0 and 2s+1 for bits 15:8, with the buffer zero-extended to 16 bits. Addresses at or beyond 2·(slot count), including the control address 0xFF, read 0.
- R3: A write to address 0xFF with code 00 snapshots the CRC and slip counters. Code 01 snapshots the remote block error counters and the retiming status. Code 10 snapshots the frame alignment word counters. Code 11 snapshots the line code counters. Buffers outside the selected group keep their values.
- R4: Only bits 1:0 of a control write are decoded. Bits 7:2 have no effect.
- R5: A snapshot copies a counter's value into its buffer and clears the counter on the same edge, so the next snapshot reports only events after that edge.
- R6: An event in the same cycle as that counter's snapshot is not lost. The counter restarts at 1.
- R7: A live counter saturates at its all-ones value (widths: CRC 10, slip 4, remote block 10, frame word 13, line code 16).
- R8: A write to address 2s+1 snapshots slot s alone. A write to address 2s has no effect on any counter or buffer.
- R9: A holding buffer changes only on a snapshot of its own slot. Events and status changes between snapshots leave every read value unchanged.
- R10: A retiming status slot captures the channel's 6-bit status input on a snapshot. It is never cleared, so repeated snapshots of an unchanged input return the same value.
- R11: Without a snapshot, a live counter below its maximum increments by exactly one in each cycle that its event strobe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| crc_err_evt | input | 16 | Block CRC error strobes, rx 0..7 then tx 0..7 |
| slip_evt | input | 16 | Transmit slip strobes, positive 0..7 then negative 0..7 |
| rbe_evt | input | 16 | Remote block error strobes, rx then tx |
| fas_err_evt | input | 16 | Frame alignment word error strobes, rx then tx |
| code_err_evt | input | 8 | Receive line code error strobes |
| rtm_status | input | 48 | Retiming status, 6 bits per channel, channel 0 in bits 5:0 |
| bus_wr | input | 1 | Write strobe, one byte per cycle |
| bus_addr | input | 8 | Byte address for reads and writes |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for bus_addr |

## Verification
The assertions assume that every strobe, status and bus input holds a known value at each rising edge. They also assume that the slot count leaves the control address above the last mapped byte, so a control write never doubles as a single-counter trigger. The bench changes every input only at the falling clock edge and keeps addresses inside the 8-bit space. Status inputs change only between snapshots where a phase intends it. A reference model in the bench advances on the same rising edge, computed from the group codes, widths and address layout above.

// File: rtl/esb_pkg.sv
package esb_pkg;
    parameter int CRC_W    = 10;
    parameter int SLIP_W   = 4;
    parameter int RBE_W    = 10;
    parameter int RTM_W    = 6;
    parameter int FAS_W    = 13;
    parameter int CODE_W   = 16;
    parameter int BUF_W    = 16;
    parameter int ADDR_W   = 8;
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'hFF;

    localparam int FAM_CRC  = 0;
    localparam int FAM_SLIP = 1;
    localparam int FAM_RBE  = 2;
    localparam int FAM_RTM  = 3;
    localparam int FAM_FAS  = 4;
    localparam int FAM_CODE = 5;

    function automatic int slot_count(int n);
        return 10 * n;
    endfunction

    function automatic int fam_base(int f, int n);
        case (f)
            FAM_CRC:  return 0;
            FAM_SLIP: return 2 * n;
            FAM_RBE:  return 4 * n;
            FAM_RTM:  return 6 * n;
            FAM_FAS:  return 7 * n;
            default:  return 9 * n;
        endcase
    endfunction

    function automatic int slot_fam(int s, int n);
        if (s < fam_base(FAM_SLIP, n)) return FAM_CRC;
        if (s < fam_base(FAM_RBE, n))  return FAM_SLIP;
        if (s < fam_base(FAM_RTM, n))  return FAM_RBE;
        if (s < fam_base(FAM_FAS, n))  return FAM_RTM;
        if (s < fam_base(FAM_CODE, n)) return FAM_FAS;
        return FAM_CODE;
    endfunction

    function automatic int fam_width(int f);
        case (f)
            FAM_CRC:  return CRC_W;
            FAM_SLIP: return SLIP_W;
            FAM_RBE:  return RBE_W;
            FAM_RTM:  return RTM_W;
            FAM_FAS:  return FAS_W;
            default:  return CODE_W;
        endcase
    endfunction

    function automatic logic [1:0] fam_group(int f);
        case (f)
            FAM_CRC, FAM_SLIP: return 2'b00;
            FAM_RBE, FAM_RTM:  return 2'b01;
            FAM_FAS:           return 2'b10;
            default:           return 2'b11;
        endcase
    endfunction

    function automatic int group_size(logic [1:0] g, int n);
        case (g)
            2'b00:   return 4 * n;
            2'b01:   return 3 * n;
            2'b10:   return 2 * n;
            default: return n;
        endcase
    endfunction
endpackage

// File: rtl/esb_counter.sv
module esb_counter #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         evt_i,
    input  logic         snap_i,
    output logic [W-1:0] hold_o
);
    localparam logic [W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [W-1:0] cnt;
        logic [W-1:0] hold;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (snap_i) begin
            st_d.hold = st_q.cnt;
            st_d.cnt  = evt_i ? W'(1) : '0;
        end else if (evt_i && (st_q.cnt != CNT_MAX)) begin
            st_d.cnt = st_q.cnt + W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign hold_o = st_q.hold;

    assert_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
        snap_i |=> st_q.hold == $past(st_q.cnt));
    assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (snap_i && !evt_i) |=> st_q.cnt == '0);
    assert_restart_one_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (snap_i && evt_i) |=> st_q.cnt == W'(1));
    assert_saturate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!snap_i && st_q.cnt == CNT_MAX) |=> st_q.cnt == CNT_MAX);
    assert_hold_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !snap_i |=> $stable(st_q.hold));
    assert_increment_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!snap_i && evt_i && st_q.cnt != CNT_MAX) |=> st_q.cnt == $past(st_q.cnt) + W'(1));
endmodule

// File: rtl/esb_status.sv
module esb_status #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         snap_i,
    input  logic [W-1:0] stat_i,
    output logic [W-1:0] hold_o
);
    typedef struct packed {
        logic [W-1:0] hold;
    } stat_state_t;

    stat_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (snap_i) st_d.hold = stat_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign hold_o = st_q.hold;

    assert_status_copy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        snap_i |=> st_q.hold == $past(stat_i));
    assert_status_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !snap_i |=> $stable(st_q.hold));
endmodule

// File: rtl/esb_bus.sv
module esb_bus
    import esb_pkg::*;
#(
    parameter int NCH = 8,
    localparam int NSLOT = slot_count(NCH)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_i,
    input  logic [ADDR_W-1:0]             addr_i,
    input  logic [7:0]                    wdata_i,
    input  logic [NSLOT-1:0][BUF_W-1:0]   bufs_i,
    output logic [NSLOT-1:0]              snap_o,
    output logic [7:0]                    rdata_o
);
    logic ctrl_wr;
    logic unused_code_hi;

    assign ctrl_wr        = wr_i && (addr_i == CTRL_ADDR);
    assign unused_code_hi = ^wdata_i[7:2];

    for (genvar s = 0; s < NSLOT; s++) begin : g_dec
        localparam logic [1:0]        GRP   = fam_group(slot_fam(s, NCH));
        localparam logic [ADDR_W-1:0] MSB_A = ADDR_W'(2 * s + 1);
        assign snap_o[s] = (ctrl_wr && (wdata_i[1:0] == GRP)) || (wr_i && (addr_i == MSB_A));
    end

    always_comb begin
        rdata_o = '0;
        for (int s = 0; s < NSLOT; s++) begin
            if (addr_i[ADDR_W-1:1] == (ADDR_W-1)'(s))
                rdata_o = addr_i[0] ? bufs_i[s][15:8] : bufs_i[s][7:0];
        end
    end

    assert_group_fanout_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |-> $countones(snap_o) == group_size(wdata_i[1:0], NCH));
    assert_single_snap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && addr_i[0] && !ctrl_wr && (int'(addr_i) < 2 * NSLOT)) |-> $countones(snap_o) == 1);
    assert_lsb_write_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !addr_i[0]) |-> snap_o == '0);
endmodule

// File: rtl/err_snap_bank.sv
module err_snap_bank
    import esb_pkg::*;
#(
    parameter int NCH = 8,
    localparam int NSLOT = slot_count(NCH)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [2*NCH-1:0]       crc_err_evt,
    input  logic [2*NCH-1:0]       slip_evt,
    input  logic [2*NCH-1:0]       rbe_evt,
    input  logic [2*NCH-1:0]       fas_err_evt,
    input  logic [NCH-1:0]         code_err_evt,
    input  logic [RTM_W*NCH-1:0]   rtm_status,
    input  logic                   bus_wr,
    input  logic [ADDR_W-1:0]      bus_addr,
    input  logic [7:0]             bus_wdata,
    output logic [7:0]             bus_rdata
);
    logic [NSLOT-1:0]            snap;
    logic [NSLOT-1:0][BUF_W-1:0] bufs;

    esb_bus #(.NCH(NCH)) u_bus (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (bus_wr),
        .addr_i  (bus_addr),
        .wdata_i (bus_wdata),
        .bufs_i  (bufs),
        .snap_o  (snap),
        .rdata_o (bus_rdata)
    );

    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        localparam int FAM = slot_fam(s, NCH);
        localparam int IDX = s - fam_base(FAM, NCH);
        localparam int W   = fam_width(FAM);

        if (FAM == FAM_RTM) begin : g_stat
            logic [W-1:0] hold;
            esb_status #(.W(W)) u_stat (
                .clk    (clk),
                .rst_n  (rst_n),
                .snap_i (snap[s]),
                .stat_i (rtm_status[IDX*RTM_W +: RTM_W]),
                .hold_o (hold)
            );
            assign bufs[s] = BUF_W'(hold);
        end else begin : g_cnt
            logic         ev;
            logic [W-1:0] hold;
            if (FAM == FAM_CRC) begin : g_ev
                assign ev = crc_err_evt[IDX];
            end else if (FAM == FAM_SLIP) begin : g_ev
                assign ev = slip_evt[IDX];
            end else if (FAM == FAM_RBE) begin : g_ev
                assign ev = rbe_evt[IDX];
            end else if (FAM == FAM_FAS) begin : g_ev
                assign ev = fas_err_evt[IDX];
            end else begin : g_ev
                assign ev = code_err_evt[IDX];
            end
            esb_counter #(.W(W)) u_cnt (
                .clk    (clk),
                .rst_n  (rst_n),
                .evt_i  (ev),
                .snap_i (snap[s]),
                .hold_o (hold)
            );
            assign bufs[s] = BUF_W'(hold);
        end
    end
endmodule

// File: tb/tb_err_snap_bank.sv
module tb_err_snap_bank;
    localparam int CLK_PERIOD = 10;
    localparam int N  = 8;
    localparam int NS = 10 * N;
    localparam logic [7:0] CTRL = 8'hFF;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NS-1:0] ev = '0;
    logic [6*N-1:0] rtm = '0;
    logic wr = 1'b0;
    logic [7:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;

    int mcnt [NS];
    int mbuf [NS];
    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    err_snap_bank dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .crc_err_evt  (ev[2*N-1:0]),
        .slip_evt     (ev[4*N-1:2*N]),
        .rbe_evt      (ev[6*N-1:4*N]),
        .fas_err_evt  (ev[9*N-1:7*N]),
        .code_err_evt (ev[10*N-1:9*N]),
        .rtm_status   (rtm),
        .bus_wr       (wr),
        .bus_addr     (addr),
        .bus_wdata    (wdata),
        .bus_rdata    (rdata)
    );

    function automatic int ew(int s);
        if (s < 2*N) return 10;
        if (s < 4*N) return 4;
        if (s < 6*N) return 10;
        if (s < 7*N) return 6;
        if (s < 9*N) return 13;
        return 16;
    endfunction

    function automatic int eg(int s);
        if (s < 4*N) return 0;
        if (s < 7*N) return 1;
        if (s < 9*N) return 2;
        return 3;
    endfunction

    function automatic bit is_st(int s);
        return (s >= 6*N) && (s < 7*N);
    endfunction

    task automatic chk(int got, int exp, string tag);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s addr=%0d actual=%0d expected=%0d", tag, addr, got, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        for (int s = 0; s < NS; s++) begin
            bit snap;
            snap = wr && ((addr == CTRL && int'(wdata[1:0]) == eg(s)) || int'(addr) == 2*s + 1);
            if (is_st(s)) begin
                if (snap) mbuf[s] = int'(rtm[(s-6*N)*6 +: 6]);
            end else if (snap) begin
                mbuf[s] = mcnt[s];
                mcnt[s] = ev[s] ? 1 : 0;
            end else if (ev[s] && mcnt[s] < (1 << ew(s)) - 1) begin
                mcnt[s] = mcnt[s] + 1;
            end
        end
        @(negedge clk);
    endtask

    task automatic check_all(string tag);
        ev = '0;
        wr = 1'b0;
        for (int a = 0; a < 256; a++) begin
            int exp;
            addr = 8'(a);
            #1;
            exp = (a < 2*NS) ? ((mbuf[a/2] >> (8*(a%2))) & 255) : 0;
            chk(int'(rdata), exp, tag);
        end
        @(negedge clk);
    endtask

    task automatic bus_write(int a, int d);
        wr = 1'b1;
        addr = 8'(a);
        wdata = 8'(d);
        tick();
        wr = 1'b0;
    endtask

    task automatic run_pattern(int cycles, int seed);
        for (int c = 0; c < cycles; c++) begin
            for (int s = 0; s < NS; s++)
                ev[s] = (((c + seed) * (s*5 + 3)) % 7) < 3;
            tick();
        end
        ev = '0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not complete, actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int s = 0; s < NS; s++) begin
            mcnt[s] = 0;
            mbuf[s] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 and R2: everything zero, unmapped space and control address read 0
        check_all("R1 R2 reset");

        // R11 counting, R3 group selection and R5 clear
        for (int i = 0; i < N; i++) rtm[i*6 +: 6] = 6'((i*11 + 5) & 63);
        run_pattern(300, 1);
        bus_write(CTRL, 0);
        check_all("R3 R11 group 00");
        bus_write(CTRL, 8'hA8 | 2);  // R4: high bits set, decoded as code 10
        check_all("R4 group 10 with high bits");
        bus_write(CTRL, 1);
        check_all("R3 R10 group 01");
        bus_write(CTRL, 8'hFC | 3);  // R4
        check_all("R4 R3 group 11");
        run_pattern(40, 7);
        bus_write(CTRL, 0);
        check_all("R5 post-clear counts");

        // R8: single-counter snapshot via upper byte, lower byte write ignored
        run_pattern(120, 3);
        for (int s = 0; s < NS; s += 7) bus_write(2*s + 1, 8'h5A);
        check_all("R8 single snapshots");
        for (int s = 1; s < NS; s += 5) bus_write(2*s, 8'h03);
        check_all("R8 lower byte write no effect");
        for (int g = 0; g < 4; g++) bus_write(CTRL, g);
        check_all("R8 counters kept after lower byte writes");

        // R9: events and status changes without snapshot leave reads unchanged
        for (int i = 0; i < N; i++) rtm[i*6 +: 6] = 6'((i*23 + 40) & 63);
        run_pattern(60, 11);
        check_all("R9 buffers stable");

        // R10: status copied on snapshot, not cleared on repeat
        bus_write(CTRL, 1);
        check_all("R10 status capture");
        bus_write(CTRL, 1);
        check_all("R10 status repeat");

        // R6: event in the same cycle as the snapshot
        ev = '1;
        bus_write(CTRL, 0);
        ev = '0;
        bus_write(CTRL, 0);
        check_all("R6 restart at one");

        // R7: saturation of every counter narrower than 14 bits
        ev = '1;
        for (int c = 0; c < 8300; c++) tick();
        ev = '0;
        for (int g = 0; g < 4; g++) bus_write(CTRL, g);
        check_all("R7 saturation");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule